// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block holds a time-alarm word and a calendar-alarm word and compares them against the running BCD time and calendar of a clock core. Each of the five alarm fields (second, minute, hour, month, day of month) carries its own enable bit inside its alarm word. Only enabled fields take part in the match. A disabled field always counts as matching. The year and the century never take part.

The clock core pulses `tick_i` in the cycle in which its counters present their freshly updated value. The comparator evaluates the match on that cycle only and raises `alarm_o` for exactly one cycle, which the core feeds into its status flag. Both alarm words are checked continuously for legal BCD content, and a flag is reported for each word. While either flag is set, the alarm is held off. In 12-hour mode the hour comparison also takes in the AM/PM bit, and the legal hour range changes.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset, `alarm_o`, `tim_alr_bad_o` and `cal_alr_bad_o` are 0, and every alarm field is disabled.
- R2: A cycle with `tim_alr_we_i` loads `wdata_i` into the time-alarm word. In that word, second is bits 6:0 (enable bit 7), minute is bits 14:8 (enable bit 15), hour is bits 21:16 (enable bit 23) and AM/PM is bit 22. A cycle with `cal_alr_we_i` loads the calendar-alarm word, where month is bits 20:16 (enable bit 23) and day of month is bits 29:24 (enable bit 31).
- R3: The current time and calendar words use the same field positions. A field whose enable is 0 matches any current value.
- R4: When all five enables are 0, `alarm_o` is never raised.
- R5: `alarm_o` is 1 in the cycle after a `tick_i` cycle in which every enabled field matches. In every other cycle it is 0, and a match without `tick_i` has no effect.
- R6: Calendar bits outside month and day of month (year, century, weekday) do not affect the match.
- R7: `tim_alr_bad_o` is 1 when an enabled time field holds a nibble above 9, when seconds or minutes exceed 59, or when the hour falls outside its legal range.
- R8: `cal_alr_bad_o` is 1 when an enabled calendar field holds a nibble above 9, when the month falls outside 1..12, or when the day of month falls outside 1..31.
- R9: While either validity flag is 1, `alarm_o` stays 0.
- R10: With `twelve_hr_i` = 1, the hour match also requires equal AM/PM bits, and the legal hour is 1..12. With `twelve_hr_i` = 0, the AM/PM bit is ignored and the legal hour is 0..23.
- R11: A disabled field is never checked for validity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counters updated this cycle |
| time_i | input | 32 | Current BCD time word |
| cal_i | input | 32 | Current BCD calendar word |
| twelve_hr_i | input | 1 | 12-hour mode |
| tim_alr_we_i | input | 1 | Write time-alarm word |
| cal_alr_we_i | input | 1 | Write calendar-alarm word |
| wdata_i | input | 32 | Write data for either alarm word |
| alarm_o | output | 1 | One-cycle alarm event |
| tim_alr_bad_o | output | 1 | Time-alarm word invalid |
| cal_alr_bad_o | output | 1 | Calendar-alarm word invalid |

## Verification
A wrongly stored alarm word, a wrong field slice or a misplaced enable bit shows up in two ways. It either yields a validity flag in the cycle right after the write, or it yields a missing or spurious `alarm_o` one cycle after the next tick. The stimulus therefore pulls the current time from the alarm fields most of the time, so that near-matches differ in a single field. Each tick is compared against a model of the stored words, and the flags are compared after every write and every mode change.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int HOUR_IDX   = 2;
  localparam int DATA_W     = 32;

  // field order: sec, min, hour, month, mday
  function automatic int fld_lsb(int i);
    case (i)
      0: return 0;  1: return 8;  2: return 16;  3: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic int fld_w(int i);
    case (i)
      0, 1: return 7;  2: return 6;  3: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int fld_en(int i);
    case (i)
      0: return 7;  1: return 15;  2, 3: return 23;
      default: return 31;
    endcase
  endfunction

  // 0: time-alarm word, 1: calendar-alarm word
  function automatic bit fld_in_cal(int i);
    return i >= 3;
  endfunction

  function automatic int fld_lo(int i);
    return (i >= 3) ? 1 : 0;
  endfunction

  function automatic int fld_hi(int i);
    case (i)
      0, 1: return 59;  2: return 23;  3: return 12;
      default: return 31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_range_chk.sv
module bcd_range_chk (
  input  logic [7:0] val_i,
  input  logic [7:0] lo_i,
  input  logic [7:0] hi_i,
  output logic       ok_o
);
  logic [7:0] bin;
  assign bin  = 8'(val_i[7:4]) * 8'd10 + 8'(val_i[3:0]);
  assign ok_o = (val_i[7:4] <= 4'd9) && (val_i[3:0] <= 4'd9) &&
                (bin >= lo_i) && (bin <= hi_i);
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W = 7
) (
  input  logic         en_i,
  input  logic [W-1:0] alarm_i,
  input  logic [W-1:0] cur_i,
  output logic         hit_o
);
  assign hit_o = !en_i || (alarm_i == cur_i);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] time_i,
  input  logic [DATA_W-1:0] cal_i,
  input  logic              twelve_hr_i,
  input  logic              tim_alr_we_i,
  input  logic              cal_alr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              alarm_o,
  output logic              tim_alr_bad_o,
  output logic              cal_alr_bad_o
);
  logic [DATA_W-1:0]     tim_alr_q, cal_alr_q;
  logic [NUM_FIELDS-1:0] en_v, hit_v, fld_ok;
  logic                  alarm_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_alr_q <= '0;
      cal_alr_q <= '0;
    end else begin
      if (tim_alr_we_i) tim_alr_q <= wdata_i;
      if (cal_alr_we_i) cal_alr_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int  LSB = fld_lsb(g);
    localparam int  W   = fld_w(g);
    localparam int  EN  = fld_en(g);
    localparam bit  CAL = fld_in_cal(g);
    localparam int  CW  = (g == HOUR_IDX) ? W + 1 : W;
    logic [W-1:0]  a_fld;
    logic [CW-1:0] a_cmp, c_cmp;
    logic [7:0]    lo, hi;
    logic          rng_ok;

    if (CAL) begin : g_cal
      assign a_fld  = cal_alr_q[LSB +: W];
      assign en_v[g] = cal_alr_q[EN];
    end else begin : g_tim
      assign a_fld  = tim_alr_q[LSB +: W];
      assign en_v[g] = tim_alr_q[EN];
    end

    if (g == HOUR_IDX) begin : g_hour
      // AM/PM bit joins the compare only in 12-hour mode
      assign a_cmp = {tim_alr_q[LSB+W] & twelve_hr_i, a_fld};
      assign c_cmp = {time_i[LSB+W] & twelve_hr_i, time_i[LSB +: W]};
      assign lo    = twelve_hr_i ? 8'd1  : 8'(fld_lo(g));
      assign hi    = twelve_hr_i ? 8'd12 : 8'(fld_hi(g));
    end else begin : g_plain
      assign a_cmp = a_fld;
      assign c_cmp = CAL ? cal_i[LSB +: W] : time_i[LSB +: W];
      assign lo    = 8'(fld_lo(g));
      assign hi    = 8'(fld_hi(g));
    end

    bcd_range_chk u_rng (
      .val_i(8'(a_fld)),
      .lo_i (lo),
      .hi_i (hi),
      .ok_o (rng_ok)
    );

    alarm_field_cmp #(.W(CW)) u_cmp (
      .en_i   (en_v[g]),
      .alarm_i(a_cmp),
      .cur_i  (c_cmp),
      .hit_o  (hit_v[g])
    );

    assign fld_ok[g] = !en_v[g] || rng_ok;
  end

  assign tim_alr_bad_o = !(&fld_ok[HOUR_IDX:0]);
  assign cal_alr_bad_o = !(&fld_ok[NUM_FIELDS-1:HOUR_IDX+1]);
  assign alarm_d = tick_i && (|en_v) && (&hit_v) && !tim_alr_bad_o && !cal_alr_bad_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_o <= 1'b0;
    else         alarm_o <= alarm_d;
  end

  logic unused_bits;
  assign unused_bits = ^{tim_alr_q[31:24], cal_alr_q[15:0], cal_alr_q[22:21], cal_alr_q[30],
                         time_i[31:23], time_i[15], time_i[7], cal_i[31:30], cal_i[23:21],
                         cal_i[15:0]};

  assert_pulse_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(tick_i));

  assert_quiet_when_bad_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(!tim_alr_bad_o && !cal_alr_bad_o));

  assert_none_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!tim_alr_q[7] && !tim_alr_q[15] && !tim_alr_q[23] && !cal_alr_q[23] && !cal_alr_q[31])
    |-> !alarm_o);

  assert_cal_flag_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cal_alr_we_i) |-> $stable(cal_alr_bad_o));
endmodule

// File: tb/bcd_alarm_cmp_tb.sv
module bcd_alarm_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, twl = 1'b0, t_we = 1'b0, c_we = 1'b0;
  logic [31:0] tm = '0, cl = '0, wd = '0;
  logic        alarm, t_bad, c_bad;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] m_ta = '0, m_ca = '0;

  always #10 clk = ~clk;

  bcd_alarm_cmp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tm), .cal_i(cl),
    .twelve_hr_i(twl), .tim_alr_we_i(t_we), .cal_alr_we_i(c_we), .wdata_i(wd),
    .alarm_o(alarm), .tim_alr_bad_o(t_bad), .cal_alr_bad_o(c_bad)
  );

  function automatic bit ok_bcd(logic [7:0] v, int lo, int hi);
    int b = int'(v[7:4]) * 10 + int'(v[3:0]);
    return v[7:4] <= 9 && v[3:0] <= 9 && b >= lo && b <= hi;
  endfunction

  function automatic bit m_tbad(logic [31:0] ta, bit tw);
    return (ta[7]  && !ok_bcd({1'b0, ta[6:0]}, 0, 59)) ||
           (ta[15] && !ok_bcd({1'b0, ta[14:8]}, 0, 59)) ||
           (ta[23] && !ok_bcd({2'b0, ta[21:16]}, tw ? 1 : 0, tw ? 12 : 23));
  endfunction

  function automatic bit m_cbad(logic [31:0] ca);
    return (ca[23] && !ok_bcd({3'b0, ca[20:16]}, 1, 12)) ||
           (ca[31] && !ok_bcd({2'b0, ca[29:24]}, 1, 31));
  endfunction

  function automatic bit m_alarm(logic [31:0] ta, ca, t, c, bit tw, bit tk);
    bit hit, any;
    hit = (!ta[7]  || ta[6:0] == t[6:0]) && (!ta[15] || ta[14:8] == t[14:8]) &&
          (!ta[23] || (ta[21:16] == t[21:16] && (!tw || ta[22] == t[22]))) &&
          (!ca[23] || ca[20:16] == c[20:16]) && (!ca[31] || ca[29:24] == c[29:24]);
    any = ta[7] || ta[15] || ta[23] || ca[23] || ca[31];
    return tk && hit && any && !m_tbad(ta, tw) && !m_cbad(ca);
  endfunction

  function automatic logic [7:0] to_bcd(int n);
    return 8'((n / 10) << 4 | (n % 10));
  endfunction

  function automatic logic [7:0] rbcd(int lo, int hi);
    return to_bcd(lo + int'($urandom % (hi - lo + 1)));
  endfunction

  task automatic chk(bit act, bit exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample at the next negedge
  task automatic step(bit twe, bit cwe, logic [31:0] d, bit tk, logic [31:0] t, c, bit tw,
                      string req);
    bit ea;
    t_we = twe; c_we = cwe; wd = d; tick = tk; tm = t; cl = c; twl = tw;
    ea = m_alarm(m_ta, m_ca, t, c, tw, tk);
    if (twe) m_ta = d;
    if (cwe) m_ca = d;
    @(posedge clk); @(negedge clk);
    chk(alarm, ea, {req, " alarm"});
    chk(t_bad, m_tbad(m_ta, tw), {req, " R7 tim_bad"});
    chk(c_bad, m_cbad(m_ca), {req, " R8 cal_bad"});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk(alarm, 1'b0, "R1 alarm"); chk(t_bad, 1'b0, "R1 tim_bad"); chk(c_bad, 1'b0, "R1 cal_bad");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 1, 32'h0012_3045, 32'h1503_2020, 0, "R4 no enables");
    // R2 R3: second only enabled
    step(1, 0, 32'h0000_00B0, 0, 0, 0, 0, "R2 write sec");
    step(0, 0, 0, 1, 32'h0017_2230, 32'h0902_1999, 0, "R3 sec hit");
    step(0, 0, 0, 1, 32'h0017_2231, 32'h0902_1999, 0, "R3 sec miss");
    step(0, 0, 0, 0, 32'h0017_2230, 32'h0902_1999, 0, "R5 no tick");
    // R7 R9: bad seconds
    step(1, 0, 32'h0000_00DA, 0, 0, 0, 0, "R7 bad sec");
    step(0, 0, 0, 1, 32'h0000_005A, 0, 0, "R9 suppress");
    // R8 R11: calendar
    step(1, 0, 32'h0000_0000, 0, 0, 0, 0, "R4 clear");
    step(0, 1, 32'h0093_0000, 0, 0, 0, 0, "R8 bad month");
    step(0, 1, 32'h9500_0000, 0, 0, 0, 0, "R11 month off");
    step(0, 0, 0, 1, 0, 32'h1512_2024, 0, "R6 date hit");
    step(0, 0, 0, 1, 0, 32'h1507_9931, 0, "R6 year ignored");
    step(0, 1, 32'h8000_0000, 0, 0, 0, 0, "R8 date zero");
    // R10: 12-hour
    step(0, 1, 0, 0, 0, 0, 0, "R2 cal clear");
    step(1, 0, 32'h00D1_0000, 0, 0, 0, 1, "R10 write hour");
    step(0, 0, 0, 1, 32'h0011_0000, 0, 1, "R10 pm mismatch");
    step(0, 0, 0, 1, 32'h0051_0000, 0, 1, "R10 pm match");
    step(0, 0, 0, 1, 32'h0011_0000, 0, 0, "R10 24h ignores pm");
    step(1, 0, 32'h0080_0000, 0, 0, 0, 1, "R10 hour zero 12h");
    step(0, 0, 0, 0, 0, 0, 0, "R10 hour zero 24h");
    step(1, 0, 32'h0093_0000, 0, 0, 0, 1, "R10 hour 13 12h");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ta, ca, t, c;
      bit tw, wt, wc;
      tw = ($urandom % 8) == 0 ? ~twl : twl;
      wt = ($urandom % 6) == 0;
      wc = ($urandom % 6) == 0;
      ta = {8'h00, ($urandom % 2) == 1, 1'($urandom), tw ? rbcd(1, 12)[5:0] : rbcd(0, 23)[5:0],
            ($urandom % 2) == 1, rbcd(0, 59)[6:0], ($urandom % 2) == 1, rbcd(0, 59)[6:0]};
      ca = {($urandom % 2) == 1, 1'b0, rbcd(1, 31)[5:0], ($urandom % 2) == 1, 2'b0,
            rbcd(1, 12)[4:0], 16'h0000};
      if (($urandom % 10) == 0) ta[6:0] = 7'($urandom);
      if (($urandom % 10) == 0) ca[20:16] = 5'($urandom);
      t = $urandom; c = $urandom;
      if (($urandom % 4) != 0) t[6:0] = m_ta[6:0];
      if (($urandom % 4) != 0) t[14:8] = m_ta[14:8];
      if (($urandom % 4) != 0) t[22:16] = m_ta[22:16];
      if (($urandom % 4) != 0) c[20:16] = m_ca[20:16];
      if (($urandom % 4) != 0) c[29:24] = m_ca[29:24];
      if (wt) step(1, 0, ta, ($urandom % 2) == 1, t, c, tw, "R3 R5 random");
      else if (wc) step(0, 1, ca, ($urandom % 2) == 1, t, c, tw, "R3 R5 random");
      else step(0, 0, $urandom, ($urandom % 3) != 0, t, c, tw, "R3 R5 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule